// File: doc/BRIEF.md
# Serial Bit-Clock and Frame-Sync Generator

This block generates the bit clock and the periodic frame-sync pulse for a synchronous serial port. It runs from the fast peripheral clock. When it is the bit-clock master, it derives the serial clock by dividing the peripheral clock. The division ratio depends on the data direction: transmit uses the shorter ratio and receive uses one twice as long. When it is a bit-clock slave, it follows an external serial clock. That clock passes through a two-flop synchronizer first.

Either serial-clock source can advance the frame counter. Each time the counter reaches the programmed frame divisor, the block raises a frame-sync pulse for one serial-clock period. Two tag outputs mark whether that frame sync belongs to a transmit or a receive transfer.

If the divisor, the frame divisor or the direction changes, both counters restart from zero. A disabled block holds its outputs low.

Top module: `sport_clkgen`

## Requirements
- R1: In transmit master mode (`dir_tx`=1, `clk_master`=1), `sclk_out` has a period of 4×(D+1) peripheral clocks, with D = `clk_div[15:1]`. It is high for exactly half of that period.
- R2: In receive master mode (`dir_tx`=0), `sclk_out` has a period of 8×(D+1) peripheral clocks and a 50% duty cycle.
- R3: Bit 0 of `clk_div` is reserved. Changing it neither alters the serial clock nor restarts it.
- R4: `fs_out` rises once every (`fs_div`+1) serial-clock periods and stays high for exactly one serial-clock period. This holds for `fs_div` ≥ 1.
- R5: When `clk_master`=0, the frame counter counts rising edges of the synchronized `ext_sclk`, and `sclk_out` stays low.
- R6: `fs_tx_tag` equals `fs_out` when `dir_tx`=1. `fs_rx_tag` equals `fs_out` when `dir_tx`=0. The other tag stays low.
- R7: A change of D, `fs_div` or `dir_tx` drives `sclk_out` and `fs_out` low in the following cycle and restarts both counters from zero.
- R8: While `enable`=0, `sclk_out`, `fs_out` and both tags stay low.
- R9: While `fs_master`=0, `fs_out` stays low. The serial clock keeps running.
- R10: Reset drives all outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable |
| clk_master | input | 1 | 1: generate the serial clock internally; 0: follow `ext_sclk` |
| fs_master | input | 1 | 1: generate frame syncs; 0: frame-sync output idle |
| dir_tx | input | 1 | 1: transmit, 0: receive |
| clk_div | input | 16 | Serial-clock divisor, bits 15:1 used, bit 0 reserved |
| fs_div | input | 16 | Serial-clock periods between frame syncs minus one |
| ext_sclk | input | 1 | External serial clock, asynchronous |
| sclk_out | output | 1 | Generated serial clock (low in slave mode) |
| fs_out | output | 1 | Frame-sync pulse |
| fs_tx_tag | output | 1 | Frame sync marked as transmit |
| fs_rx_tag | output | 1 | Frame sync marked as receive |

## Verification
The assertions assume the configuration inputs change only between peripheral-clock edges. They also assume `rst_n` is the only asynchronous control. The bench follows this by driving every input on the falling edge.

The assertions also assume `ext_sclk` stays high and low for several peripheral clocks, so the synchronizer sees every edge. The bench drives it with a period of ten peripheral clocks.

The frame-sync checks use frame divisors of at least one, because a divisor of zero would hold the pulse high permanently.

// File: rtl/sport_clkgen.sv
module sport_clkgen #(
  parameter int DIV_W = 16,
  parameter int FS_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             clk_master,
  input  logic             fs_master,
  input  logic             dir_tx,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [FS_W-1:0]  fs_div,
  input  logic             ext_sclk,
  output logic             sclk_out,
  output logic             fs_out,
  output logic             fs_tx_tag,
  output logic             fs_rx_tag
);
  localparam int CW  = DIV_W - 1;
  localparam int HW  = DIV_W + 2;
  localparam int CFW = CW + FS_W + 1;

  logic [CW-1:0]  cdiv;
  logic [HW-1:0]  base, half, hcnt;
  logic [CFW-1:0] cfg_now, cfg_q;
  logic [FS_W-1:0] fcnt;
  logic [2:0]     ext_s;
  logic           sclk_q, fs_q, chg, int_rise, ext_rise, srise;

  assign cdiv    = clk_div[DIV_W-1:1];
  assign base    = HW'(cdiv) + HW'(1);
  assign half    = dir_tx ? (base << 1) : (base << 2);
  assign cfg_now = {cdiv, fs_div, dir_tx};
  assign chg     = cfg_now != cfg_q;

  assign int_rise = clk_master && !sclk_q && (hcnt == half - HW'(1));
  assign ext_rise = !clk_master && ext_s[1] && !ext_s[2];
  assign srise    = enable && !chg && (int_rise || ext_rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      hcnt   <= '0;
      sclk_q <= 1'b0;
      ext_s  <= '0;
    end else begin
      cfg_q <= cfg_now;
      ext_s <= {ext_s[1:0], ext_sclk};
      if (!enable || chg || !clk_master) begin
        hcnt   <= '0;
        sclk_q <= 1'b0;
      end else if (hcnt == half - HW'(1)) begin
        hcnt   <= '0;
        sclk_q <= ~sclk_q;
      end else begin
        hcnt <= hcnt + HW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt <= '0;
      fs_q <= 1'b0;
    end else if (!enable || chg || !fs_master) begin
      fcnt <= '0;
      fs_q <= 1'b0;
    end else if (srise) begin
      if (fcnt == fs_div) begin
        fcnt <= '0;
        fs_q <= 1'b1;
      end else begin
        fcnt <= fcnt + FS_W'(1);
        fs_q <= 1'b0;
      end
    end
  end

  assign sclk_out  = sclk_q;
  assign fs_out    = fs_q;
  assign fs_tx_tag = fs_q &  cfg_q[0];
  assign fs_rx_tag = fs_q & ~cfg_q[0];

  a_r1_half_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !chg |-> hcnt < half);
  a_r4_fcnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !chg |-> fcnt <= fs_div);
  a_r4_fs_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fs_out) |-> $past(srise));
  a_r8_idle_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !fs_out && !sclk_out);
  a_r9_fs_slave: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_master |=> !fs_out);
  a_r5_slave_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_master |=> !sclk_out);
  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> !sclk_out && !fs_out);
endmodule

// File: tb/sim_sport_clkgen.sv
`timescale 1ns/1ps
module sim_sport_clkgen;
  logic clk = 0, rst_n = 0, enable = 0, clk_master = 1, fs_master = 1, dir_tx = 1;
  logic [15:0] clk_div = '0, fs_div = 16'd1;
  logic ext_sclk = 0, ext_run = 0;
  logic sclk_out, fs_out, fs_tx_tag, fs_rx_tag;
  int checks = 0, errors = 0;
  bit done = 0;

  sport_clkgen u0 (.*);

  always #4 clk = ~clk;

  initial forever begin
    @(negedge clk);
    if (ext_run) begin
      repeat (4) @(negedge clk);
      ext_sclk = ~ext_sclk;
    end else ext_sclk = 0;
  end

  localparam int NV = 6;
  localparam bit     V_DIR [NV] = '{1, 1, 0, 0, 1, 0};
  localparam int     V_CD  [NV] = '{0, 2, 0, 1, 3, 2};
  localparam int     V_FS  [NV] = '{1, 3, 2, 1, 4, 1};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit sig(input bit f);
    return f ? fs_out : sclk_out;
  endfunction

  task automatic meas(input bit f, output int per, output int hi);
    int n;
    n = 0; while (sig(f) && n < 4000) begin @(negedge clk); n++; end
    n = 0; while (!sig(f) && n < 4000) begin @(negedge clk); n++; end
    per = 0; hi = 0;
    while (sig(f) && per < 4000) begin @(negedge clk); per++; hi++; end
    while (!sig(f) && per < 4000) begin @(negedge clk); per++; end
  endtask

  task automatic wait_hi(input bit f);
    int n;
    n = 0; while (sig(f) && n < 4000) begin @(negedge clk); n++; end
    n = 0; while (!sig(f) && n < 4000) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int per, hi, p, n;
    repeat (3) @(negedge clk);
    chk("R10 sclk reset", sclk_out, 0);
    chk("R10 fs reset", fs_out, 0);
    chk("R10 tags reset", fs_tx_tag | fs_rx_tag, 0);
    rst_n = 1; enable = 1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      dir_tx = V_DIR[i]; clk_div = 16'(V_CD[i] << 1); fs_div = 16'(V_FS[i]);
      p = (V_DIR[i] ? 4 : 8) * (V_CD[i] + 1);
      meas(0, per, hi);
      chk(V_DIR[i] ? "R1 sclk period" : "R2 sclk period", per, p);
      chk(V_DIR[i] ? "R1 sclk high" : "R2 sclk high", hi, p / 2);
      meas(1, per, hi);
      chk("R4 fs period", per, p * (V_FS[i] + 1));
      chk("R4 fs high", hi, p);
      wait_hi(1);
      chk("R6 tx tag", fs_tx_tag, V_DIR[i]);
      chk("R6 rx tag", fs_rx_tag, !V_DIR[i]);
    end

    // R3: reserved bit toggled mid high phase, no restart
    @(negedge clk); dir_tx = 1; clk_div = 16'd2; fs_div = 16'd2;
    wait_hi(0);
    clk_div = 16'd3;
    @(negedge clk);
    chk("R3 no restart", sclk_out, 1);
    meas(0, per, hi);
    chk("R3 period kept", per, 8);

    // R7: frame divisor change restarts
    wait_hi(0);
    fs_div = 16'd3;
    @(negedge clk);
    chk("R7 sclk restart", sclk_out, 0);
    chk("R7 fs restart", fs_out, 0);
    meas(1, per, hi);
    chk("R7 new fs period", per, 32);

    // R7: direction change restarts
    wait_hi(0);
    dir_tx = 0;
    @(negedge clk);
    chk("R7 dir restart", sclk_out, 0);
    meas(0, per, hi);
    chk("R7 dir period", per, 16);

    // R9: frame-sync slave
    @(negedge clk); fs_master = 0; dir_tx = 1; clk_div = 16'd0; fs_div = 16'd1;
    n = 0; hi = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      n += fs_out; hi += sclk_out;
    end
    chk("R9 fs idle", n, 0);
    chk("R9 sclk runs", hi, 50);
    fs_master = 1;

    // R5: external serial clock
    @(negedge clk); clk_master = 0; fs_div = 16'd2; ext_run = 1;
    meas(1, per, hi);
    chk("R5 ext fs period", per, 30);
    chk("R5 ext fs high", hi, 10);
    n = 0;
    for (int k = 0; k < 40; k++) begin @(negedge clk); n += sclk_out; end
    chk("R5 sclk low", n, 0);
    ext_run = 0; clk_master = 1;

    // R8: disabled
    @(negedge clk); enable = 0;
    @(negedge clk);
    n = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      n += sclk_out + fs_out + fs_tx_tag + fs_rx_tag;
    end
    chk("R8 outputs low", n, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule